// File: doc/BRIEF.md
# TMDS channel symbol decoder

This block takes one colour channel of a TMDS link as parallel 10-bit words, one word per pixel clock. The words come from a deserialiser whose word boundary is arbitrary. A word aligner slides a 10-bit window across each pair of consecutive words. It settles on the bit offset at which the high-transition control symbols sent during blanking show up. A symbol decoder then recovers three things from each aligned symbol: the data-enable state, the 2-bit control pair during blanking, and the 8-bit pixel value during active video.

The enable state is taken only from the symbol alphabet. A symbol that matches one of the four reserved control codes means blanking, and any other symbol is pixel data. For a data symbol, the decoder first removes the optional inversion of the low byte. It then undoes the XOR or XNOR chaining that the transmitter applied. Until the aligner reports lock, the decoder forces every output to zero.

Top module: `tmds_chan_decoder`

## Requirements
- R1: When a locked symbol equals one of the control codes, de_o goes low and ctrl_o shows its pair. The codes, written bit 9 down to bit 0, are 1101010100 for pair 00, 0010101011 for pair 01, 0101010100 for pair 10 and 1010101011 for pair 11.
- R2: In a data symbol, bit 9 set means bits 7..0 are complemented before the chain is undone. Bit 9 clear means they are used as received.
- R3: In a data symbol, data_o bit 0 equals the (de-inverted) bit 0. Each higher data_o bit i is the XOR of de-inverted bits i and i-1 when symbol bit 8 is 1, and their XNOR when bit 8 is 0.
- R4: While de_o is high, ctrl_o keeps the last pair decoded during blanking.
- R5: While de_o is low, data_o is zero.
- R6: The window at offset k (k = 0..9) is formed from the current and previous input words. It starts k bits before the current word's bit 0, and bit 0 is the earliest bit in time. With offset 0, a symbol presented on raw_i shows up on the outputs exactly 2 clocks later.
- R7: locked_o rises one clock after the window at the current offset has been a control code 8 times in a row. The 8th such symbol still comes out as zeros, and the 9th is decoded.
- R8: Before lock, and from reset, de_o, data_o, ctrl_o and locked_o are all zero.
- R9: A symbol is invalid when it is not a control code and its bits 7..0 have more than 4 transitions between adjacent bits. After 8 invalid windows in a row, the offset advances by one bit (wrapping from 9 to 0) and lock is dropped. This lets the block lock onto a stream shifted by any number of bits, and a symbol is then decoded 3 clocks after the word that carries its first bit.
- R10: A valid symbol restarts the invalid run, so runs of 7 invalid symbols separated by valid ones never drop lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 10 | Deserialised word, earliest bit in bit 0 |
| data_o | output | 8 | Recovered pixel byte |
| ctrl_o | output | 2 | Recovered control pair (bit 1 = c1, bit 0 = c0) |
| de_o | output | 1 | Recovered data enable |
| locked_o | output | 1 | Word alignment lock |

## Verification
Aligned streams first repeat a single control code to reach lock. They then cycle through all four control codes, which separates the pair mapping from the enable decision. Data symbols cover all four combinations of bit 9 and bit 8, so inversion errors can be told apart from chaining errors and from the hold of the control pair. Runs of high-transition symbols, sometimes broken by valid data, separate the slip threshold from the run-restart rule. Bit streams shifted by 3 and by 7 bits show that the searcher reaches lock and that the extra word of latency follows.

// File: rtl/tmds_dec_pkg.sv
package tmds_dec_pkg;
  localparam int SYM_W          = 10;
  localparam int DAT_W          = 8;
  localparam int N_CTL          = 4;
  localparam int MAX_DATA_TRANS = 4;

  // index = control pair {c1,c0}
  localparam logic [SYM_W-1:0] CTL_SYM [N_CTL] = '{
    10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011
  };

  typedef struct packed {
    logic       hit;
    logic [1:0] pair;
  } ctl_match_t;

  function automatic ctl_match_t ctl_match(input logic [SYM_W-1:0] s);
    ctl_match_t m;
    m = '0;
    for (int i = 0; i < N_CTL; i++) begin
      if (s == CTL_SYM[i]) begin
        m.hit  = 1'b1;
        m.pair = 2'(i);
      end
    end
    return m;
  endfunction

  // low-transition test for a plausible data symbol
  function automatic logic data_ok(input logic [SYM_W-1:0] s);
    logic [DAT_W-2:0] t;
    t = s[DAT_W-1:1] ^ s[DAT_W-2:0];
    return $countones(t) <= MAX_DATA_TRANS;
  endfunction
endpackage

// File: rtl/tmds_word_aligner.sv
module tmds_word_aligner
  import tmds_dec_pkg::*;
#(
  parameter int LOCK_RUN = 8,
  parameter int SLIP_RUN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] raw_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             sym_lock_o,
  output logic             locked_o
);
  localparam int RUN_MAX = (LOCK_RUN > SLIP_RUN) ? LOCK_RUN : SLIP_RUN;
  localparam int CW      = $clog2(RUN_MAX + 1);
  localparam int OW      = $clog2(SYM_W);

  logic [SYM_W-1:0]   prev_q;
  logic [2*SYM_W-1:0] hist;
  logic [SYM_W-1:0]   win [SYM_W];
  logic [SYM_W-1:0]   cur;
  logic [OW-1:0]      ofs_q;
  logic [CW-1:0]      ctl_run_q, bad_run_q;
  logic               lock_q;
  ctl_match_t         cm;
  logic               is_ctl, is_bad;

  assign hist = {raw_i, prev_q};

  // offset k: symbol begins k bits before current word boundary
  for (genvar k = 0; k < SYM_W; k++) begin : g_win
    assign win[k] = hist[SYM_W-k +: SYM_W];
  end

  assign cur    = win[ofs_q];
  assign cm     = ctl_match(cur);
  assign is_ctl = cm.hit;
  assign is_bad = !cm.hit && !data_ok(cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      sym_o      <= '0;
      sym_lock_o <= 1'b0;
      ofs_q      <= '0;
      ctl_run_q  <= '0;
      bad_run_q  <= '0;
      lock_q     <= 1'b0;
    end else begin
      prev_q     <= raw_i;
      sym_o      <= cur;
      sym_lock_o <= lock_q;
      if (is_bad) begin
        ctl_run_q <= '0;
        if (bad_run_q == CW'(SLIP_RUN - 1)) begin
          bad_run_q <= '0;
          lock_q    <= 1'b0;
          ofs_q     <= (ofs_q == OW'(SYM_W - 1)) ? '0 : ofs_q + 1'b1;
        end else begin
          bad_run_q <= bad_run_q + 1'b1;
        end
      end else begin
        bad_run_q <= '0;
        if (is_ctl && !lock_q) begin
          if (ctl_run_q == CW'(LOCK_RUN - 1)) begin
            ctl_run_q <= '0;
            lock_q    <= 1'b1;
          end else begin
            ctl_run_q <= ctl_run_q + 1'b1;
          end
        end else if (!is_ctl) begin
          ctl_run_q <= '0;
        end
      end
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/tmds_sym_decode.sv
module tmds_sym_decode
  import tmds_dec_pkg::*;
(
  input  logic [SYM_W-1:0] sym_i,
  output logic             is_ctl_o,
  output logic [1:0]       pair_o,
  output logic [DAT_W-1:0] data_o
);
  ctl_match_t       cm;
  logic [DAT_W-1:0] q;

  assign cm       = ctl_match(sym_i);
  assign is_ctl_o = cm.hit;
  assign pair_o   = cm.pair;

  assign q         = sym_i[9] ? ~sym_i[DAT_W-1:0] : sym_i[DAT_W-1:0];
  assign data_o[0] = q[0];

  for (genvar i = 1; i < DAT_W; i++) begin : g_chain
    assign data_o[i] = sym_i[8] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
  end
endmodule

// File: rtl/tmds_chan_decoder.sv
module tmds_chan_decoder
  import tmds_dec_pkg::*;
#(
  parameter int LOCK_RUN = 8,
  parameter int SLIP_RUN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] raw_i,
  output logic [DAT_W-1:0] data_o,
  output logic [1:0]       ctrl_o,
  output logic             de_o,
  output logic             locked_o
);
  logic [SYM_W-1:0] sym_s1;
  logic             lock_s1;
  logic             dec_ctl;
  logic [1:0]       dec_pair;
  logic [DAT_W-1:0] dec_data;

  tmds_word_aligner #(
    .LOCK_RUN(LOCK_RUN),
    .SLIP_RUN(SLIP_RUN)
  ) u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_i),
    .sym_o     (sym_s1),
    .sym_lock_o(lock_s1),
    .locked_o  (locked_o)
  );

  tmds_sym_decode u_dec (
    .sym_i   (sym_s1),
    .is_ctl_o(dec_ctl),
    .pair_o  (dec_pair),
    .data_o  (dec_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o   <= 1'b0;
      data_o <= '0;
      ctrl_o <= '0;
    end else if (!lock_s1) begin
      de_o   <= 1'b0;
      data_o <= '0;
      ctrl_o <= '0;
    end else if (dec_ctl) begin
      de_o   <= 1'b0;
      data_o <= '0;
      ctrl_o <= dec_pair;
    end else begin
      de_o   <= 1'b1;
      data_o <= dec_data;
    end
  end
endmodule

// File: rtl/tmds_chan_decoder_chk.sv
module tmds_chan_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] sym_s1,
  input logic       lock_s1,
  input logic [7:0] data_o,
  input logic [1:0] ctrl_o,
  input logic       de_o,
  input logic       locked_o
);
  AST_PRELOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(locked_o, 2) |-> (!de_o && data_o == 8'h00 && ctrl_o == 2'b00)); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> $stable(ctrl_o)); // R4

  AST_BLANK_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> data_o == 8'h00); // R5

  AST_CTL_PAIR_00: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s1 && sym_s1 == 10'b1101010100) |=> (!de_o && ctrl_o == 2'b00)); // R1

  AST_CTL_PAIR_11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_s1 && sym_s1 == 10'b1010101011) |=> (!de_o && ctrl_o == 2'b11)); // R1
endmodule

bind tmds_chan_decoder tmds_chan_decoder_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sym_s1  (sym_s1),
  .lock_s1 (lock_s1),
  .data_o  (data_o),
  .ctrl_o  (ctrl_o),
  .de_o    (de_o),
  .locked_o(locked_o)
);

// File: tb/sim_tmds_chan_decoder.sv
`timescale 1ns/1ps
module sim_tmds_chan_decoder;
  localparam logic [9:0] C00 = 10'b1101010100;
  localparam logic [9:0] C01 = 10'b0010101011;
  localparam logic [9:0] C10 = 10'b0101010100;
  localparam logic [9:0] C11 = 10'b1010101011;
  localparam logic [9:0] BAD = 10'b0001010101;
  localparam logic [9:0] D1  = 10'b0100001111;
  localparam logic [9:0] D2  = 10'b1011110000;
  localparam logic [9:0] D3  = 10'b0000110011;
  localparam logic [9:0] D4  = 10'b1100000001;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] raw_i = '0;
  logic [7:0] data_o;
  logic [1:0] ctrl_o;
  logic       de_o, locked_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmds_chan_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni), .raw_i(raw_i),
    .data_o(data_o), .ctrl_o(ctrl_o), .de_o(de_o), .locked_o(locked_o)
  );

  // expected-output pipeline, two deep
  bit         pv0, pv1;
  logic       pde0, pde1;
  logic [7:0] pd0, pd1;
  logic [1:0] pc0, pc1;
  string      pt0, pt1;
  logic [1:0] held;

  task automatic check3(input string tag, input logic e_de, input logic [7:0] e_d, input logic [1:0] e_c);
    n_chk++;
    if (de_o !== e_de || data_o !== e_d || ctrl_o !== e_c) begin
      n_fail++;
      $display("FAIL %s: actual de=%b data=%h ctrl=%b expected de=%b data=%h ctrl=%b",
               tag, de_o, data_o, ctrl_o, e_de, e_d, e_c);
    end
  endtask

  task automatic check_locked(input logic e, input string tag);
    n_chk++;
    if (locked_o !== e) begin
      n_fail++;
      $display("FAIL %s: actual locked=%b expected locked=%b", tag, locked_o, e);
    end
  endtask

  function automatic logic [7:0] ref_data(input logic [9:0] s);
    logic [7:0] q, d;
    q = s[9] ? ~s[7:0] : s[7:0];
    d[0] = q[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (q[i] ^ q[i-1]) : (q[i] ~^ q[i-1]);
    return d;
  endfunction

  task automatic ref_model(input logic [9:0] s, input bit lk,
                           output logic de, output logic [7:0] d, output logic [1:0] c);
    if (!lk) begin
      de = 0; d = 0; c = 0; held = 0;
    end else begin
      case (s)
        C00: begin de = 0; d = 0; c = 2'b00; held = c; end
        C01: begin de = 0; d = 0; c = 2'b01; held = c; end
        C10: begin de = 0; d = 0; c = 2'b10; held = c; end
        C11: begin de = 0; d = 0; c = 2'b11; held = c; end
        default: begin de = 1; d = ref_data(s); c = held; end
      endcase
    end
  endtask

  // aligned send: checks the word sent two cycles earlier, then drives
  task automatic send(input logic [9:0] s, input bit lk, input string tag);
    logic m_de; logic [7:0] m_d; logic [1:0] m_c;
    @(negedge clk);
    if (pv1) check3(pt1, pde1, pd1, pc1);
    ref_model(s, lk, m_de, m_d, m_c);
    pv1 = pv0; pde1 = pde0; pd1 = pd0; pc1 = pc0; pt1 = pt0;
    pv0 = 1;   pde0 = m_de; pd0 = m_d; pc0 = m_c; pt0 = tag;
    raw_i = s;
  endtask

  task automatic do_reset();
    pv0 = 0; pv1 = 0; held = 0;
    @(negedge clk);
    rst_ni = 0; raw_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic lock_aligned();
    for (int i = 0; i < 8; i++) send(C01, 0, "R7 prelock");
    check_locked(0, "R7 seven windows");
    send(C01, 1, "R7 ninth decoded");
    check_locked(1, "R7 lock after eight");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check3("R8 reset", 0, 8'h00, 2'b00);
    check_locked(0, "R8 reset");
  endtask

  task automatic t_ctrl_codes();
    do_reset();
    lock_aligned();
    send(C00, 1, "R1 pair00");
    send(C11, 1, "R1 pair11");
    send(C10, 1, "R1 pair10");
    send(C01, 1, "R1 pair01");
    send(C10, 1, "R1 pair10 again");
    send(C10, 1, "R6 flush");
    send(C10, 1, "R6 flush");
  endtask

  task automatic t_data();
    do_reset();
    lock_aligned();
    send(C11, 1, "R1 blank");
    send(D1, 1, "R3 xor noinv");
    send(D2, 1, "R2 R3 xnor inv");
    send(D3, 1, "R3 xnor noinv R4");
    send(D4, 1, "R2 xor inv R4");
    send(C10, 1, "R5 blank zero");
    send(D3, 1, "R4 hold 10");
    send(C00, 1, "R5 blank");
    send(C00, 1, "R6 flush");
    send(C00, 1, "R6 flush");
  endtask

  task automatic t_latency();
    do_reset();
    lock_aligned();
    send(C00, 1, "R6 blank");
    @(negedge clk); raw_i = D1;
    @(negedge clk); raw_i = C00;
    n_chk++;
    if (de_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R6 one clock: actual de=%b expected de=0", de_o);
    end
    @(negedge clk);
    check3("R6 two clocks", 1, ref_data(D1), 2'b00);
    pv0 = 0; pv1 = 0;
  endtask

  task automatic t_slip();
    do_reset();
    lock_aligned();
    for (int i = 0; i < 7; i++) send(BAD, 1, "R10 bad run");
    send(D1, 1, "R10 valid breaks run");
    for (int i = 0; i < 7; i++) send(BAD, 1, "R10 bad run2");
    send(D3, 1, "R10 valid");
    check_locked(1, "R10 lock kept");
    for (int i = 0; i < 8; i++) send(BAD, 1, "R9 bad run");
    check_locked(1, "R9 seven bad");
    send(C00, 0, "R9 after slip");
    check_locked(0, "R9 lock dropped");
    send(C00, 0, "R8 unlocked zero");
    send(C00, 0, "R8 unlocked zero");
    send(C00, 0, "R8 flush");
  endtask

  // bit-shifted stream
  logic [29:0] acc;
  int          acc_n;

  task automatic push_stream(input logic [9:0] s);
    acc = acc | (30'(s) << acc_n);
    acc_n += 10;
    @(negedge clk);
    raw_i = acc[9:0];
    acc = acc >> 10;
    acc_n -= 10;
  endtask

  task automatic t_misaligned(input int shift);
    int n;
    do_reset();
    acc = '0; acc_n = shift;
    n = 0;
    while (!locked_o && n < 200) begin
      push_stream(C00);
      n++;
    end
    check_locked(1, $sformatf("R9 lock with shift %0d", shift));
    for (int i = 0; i < 3; i++) push_stream(C00);
    push_stream(D2);
    push_stream(C00);
    push_stream(C00);
    check3($sformatf("R9 before data shift %0d", shift), 0, 8'h00, 2'b00);
    push_stream(C00);
    check3($sformatf("R9 data shift %0d", shift), 1, ref_data(D2), 2'b00);
    push_stream(C11);
    push_stream(C11);
  endtask

  initial begin
    #(200000 * 5.0);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ctrl_codes();
    t_data();
    t_latency();
    t_slip();
    t_misaligned(3);
    t_misaligned(7);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule